// File: doc/BRIEF.md
# Dual-Gated Binary Up-Counter

This block is a binary up-counter, 8 bits wide by default, whose counting is controlled by a one-bit run register. The run register is written on each rising clock edge from two synchronous gate inputs. It is written with their XNOR, so the counter runs when the two gates agree and freezes when they differ. An asynchronous start input sets the run register at once and forces counting while it is held high, whatever the gates say. An asynchronous reset clears both the count and the run register. It has the highest priority.

The block gives the count in true and inverted form. It suits clock-division and time-measurement datapaths. In those uses a stopped counter must keep its value exactly until either gate pattern or the start input lets it run again. It is a fully synchronous model of a ripple counter: every count bit changes on the same clock edge.

Top module: `gated_ripple_count`

## Requirements
- R1: While `rst_async` is high, `cnt_q` is 0 and the run register is cleared. This happens without waiting for a clock edge, and it overrides `start_async` and both gates.
- R2: On each rising clock edge at which the run register holds 1, or `start_async` is high, `cnt_q` increases by exactly 1.
- R3: On each rising clock edge with `rst_async` and `start_async` low, the run register loads `~(gate_a ^ gate_b)`. A gate pattern sampled at edge k therefore governs counting from edge k+1. Right after reset is released the first edge does not count.
- R4: When exactly one of `gate_a` and `gate_b` is high at edge k, and `start_async` is low, `cnt_q` holds its value on every edge after k for as long as the pattern persists.
- R5: A rising `start_async` sets the run register immediately. While `start_async` is high the counter advances on every edge, whatever the gates say. After it drops, the run register stays set until the next edge reloads it from the gates.
- R6: A stopped counter resumes counting when both gates are made high (one edge later) or when `start_async` is raised (from the next edge).
- R7: From the all-ones value an advancing edge gives 0. There is no carry-out.
- R8: `cnt_qb` is the bitwise complement of `cnt_q` at all times.
- R9: With `rst_async` and `start_async` both high, `cnt_q` stays 0 across clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_async | input | 1 | Asynchronous reset, active high |
| start_async | input | 1 | Asynchronous run override, active high |
| gate_a | input | 1 | Synchronous gate input, XNOR-combined with gate_b |
| gate_b | input | 1 | Synchronous gate input, XNOR-combined with gate_a |
| cnt_q | output | CNT_W | Count value |
| cnt_qb | output | CNT_W | Bitwise complement of the count |

## Verification
The counter is driven with all four gate combinations. Both-low and both-high must count alike, and either mixed pattern must freeze the count one edge after it is sampled. This one-edge latency tells a registered run bit apart from a combinational gate. The start input is pulsed while the counter is stopped, which shows that it overrides the gates and that the run register stays set for one edge after release. Reset is raised between edges, alone and together with start, to show that the clear is asynchronous and has priority. A long run through the all-ones value checks the wrap and the carry chain through every bit.

// File: rtl/gc_pkg.sv
`timescale 1ns/1ps
package gc_pkg;

   // Legal range for the count width
   localparam int GC_MIN_W = 2;
   localparam int GC_MAX_W = 32;

   // Count-core implementation variants
   typedef enum logic {
      GC_CORE_TOGGLE = 1'b0,
      GC_CORE_ADDER  = 1'b1
   } gc_core_e;

   // Run decision from the two gates: run when they agree
   function automatic logic gc_gates_agree(input logic a, input logic b);
      return ~(a ^ b);
   endfunction

endpackage

// File: rtl/gc_run_reg.sv
`timescale 1ns/1ps
module gc_run_reg
   import gc_pkg::*;
(
   input  logic clk,
   input  logic rst_async,
   input  logic start_async,
   input  logic gate_a,
   input  logic gate_b,
   output logic run_q
);

   logic run_d;

   always_comb begin
      run_d = gc_gates_agree(gate_a, gate_b);
   end

   // Reset dominates the asynchronous set; otherwise load the gate decision
   always_ff @(posedge clk or posedge rst_async or posedge start_async) begin
      if (rst_async) begin
         run_q <= 1'b0;
      end else if (start_async) begin
         run_q <= 1'b1;
      end else begin
         run_q <= run_d;
      end
   end

endmodule

// File: rtl/gc_count_core.sv
`timescale 1ns/1ps
module gc_count_core
   import gc_pkg::*;
#(
   parameter int       CNT_W = 8,
   parameter gc_core_e CORE  = GC_CORE_TOGGLE
) (
   input  logic             clk,
   input  logic             rst_async,
   input  logic             adv,
   output logic [CNT_W-1:0] q
);

   localparam int CHAIN_N = CNT_W + 1;

   generate
      if (CORE == GC_CORE_ADDER) begin : g_adder
         logic [CNT_W-1:0] acc_q;
         always_ff @(posedge clk or posedge rst_async) begin
            if (rst_async) begin
               acc_q <= '0;
            end else if (adv) begin
               acc_q <= acc_q + {{(CNT_W-1){1'b0}}, 1'b1};
            end
         end
         assign q = acc_q;
      end else begin : g_toggle
         // carry[i] is high when every bit below i is one and the count advances
         logic [CHAIN_N-1:0] carry;
         assign carry[0] = adv;
         for (genvar i = 0; i < CNT_W; i++) begin : g_bit
            logic bit_q;
            always_ff @(posedge clk or posedge rst_async) begin
               if (rst_async) begin
                  bit_q <= 1'b0;
               end else if (carry[i]) begin
                  bit_q <= ~bit_q;
               end
            end
            assign carry[i+1] = carry[i] & bit_q;
            assign q[i]       = bit_q;
         end
      end
   endgenerate

endmodule

// File: rtl/gated_ripple_count.sv
`timescale 1ns/1ps
module gated_ripple_count
   import gc_pkg::*;
#(
   parameter int       CNT_W = 8,
   parameter gc_core_e CORE  = GC_CORE_TOGGLE
) (
   input  logic             clk,
   input  logic             rst_async,
   input  logic             start_async,
   input  logic             gate_a,
   input  logic             gate_b,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_qb
);

   generate
      if (CNT_W < GC_MIN_W || CNT_W > GC_MAX_W) begin : g_bad_width
         $error("gated_ripple_count: CNT_W out of range");
      end
   endgenerate

   logic             run_q;
   logic             adv;
   logic [CNT_W-1:0] core_q;

   gc_run_reg u_run (
      .clk         (clk),
      .rst_async   (rst_async),
      .start_async (start_async),
      .gate_a      (gate_a),
      .gate_b      (gate_b),
      .run_q       (run_q)
   );

   // The start input acts directly as well, so it overrides the gates on the same edge
   assign adv = run_q | start_async;

   gc_count_core #(
      .CNT_W (CNT_W),
      .CORE  (CORE)
   ) u_core (
      .clk       (clk),
      .rst_async (rst_async),
      .adv       (adv),
      .q         (core_q)
   );

   assign cnt_q  = core_q;
   assign cnt_qb = ~core_q;

endmodule

// File: rtl/gated_ripple_count_chk.sv
`timescale 1ns/1ps
module gated_ripple_count_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_async,
   input logic             start_async,
   input logic             gate_a,
   input logic             gate_b,
   input logic             run_q,
   input logic [CNT_W-1:0] cnt_q
);

   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst_async |-> (cnt_q == '0 && !run_q));

   // R2
   advance_step_chk: assert property (@(posedge clk) disable iff (rst_async)
      (run_q || start_async) |=> (cnt_q == $past(cnt_q) + ONE));

   // R3
   run_load_chk: assert property (@(posedge clk) disable iff (rst_async || start_async)
      !$past(rst_async) |=> (run_q == !($past(gate_a) ^ $past(gate_b))));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (rst_async)
      (!run_q && !start_async) |=> $stable(cnt_q));

   // R5
   start_sets_run_chk: assert property (@(posedge clk) disable iff (rst_async)
      (start_async && !$past(rst_async)) |-> run_q);

   // R7
   wrap_zero_chk: assert property (@(posedge clk) disable iff (rst_async)
      (cnt_q == FULL && (run_q || start_async)) |=> (cnt_q == '0));

endmodule

bind gated_ripple_count gated_ripple_count_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_async   (rst_async),
   .start_async (start_async),
   .gate_a      (gate_a),
   .gate_b      (gate_b),
   .run_q       (run_q),
   .cnt_q       (cnt_q)
);

// File: tb/gated_ripple_count_test.sv
`timescale 1ns/1ps
module gated_ripple_count_test;

   localparam int W = 8;

   logic         clk         = 1'b0;
   logic         rst_async   = 1'b0;
   logic         start_async = 1'b0;
   logic         gate_a      = 1'b0;
   logic         gate_b      = 1'b0;
   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_qb;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Reference model state
   logic [W-1:0] m_cnt = '0;
   logic         m_run = 1'b0;

   always #4 clk = ~clk;

   gated_ripple_count #(.CNT_W(W)) uut (
      .clk         (clk),
      .rst_async   (rst_async),
      .start_async (start_async),
      .gate_a      (gate_a),
      .gate_b      (gate_b),
      .cnt_q       (cnt_q),
      .cnt_qb      (cnt_qb)
   );

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic chk_out(input string req);
      chk(req, cnt_q, m_cnt);
      chk("R8", cnt_qb, ~m_cnt);
   endtask

   // One clock edge: update the model at the edge, compare at the falling edge
   task automatic step(input string req);
      logic adv;
      @(posedge clk);
      if (rst_async) begin
         m_cnt = '0;
         m_run = 1'b0;
      end else begin
         adv = m_run | start_async;
         if (adv) m_cnt = m_cnt + 1'b1;
         m_run = start_async ? 1'b1 : ~(gate_a ^ gate_b);
      end
      @(negedge clk);
      chk_out(req);
   endtask

   task automatic set_start(input logic v);
      start_async = v;
      if (v && !rst_async) m_run = 1'b1;
   endtask

   task automatic t_reset;
      #1 rst_async = 1'b1;
      @(negedge clk);
      chk("R1", cnt_q, '0);
      chk("R8", cnt_qb, '1);
      step("R1");
      step("R1");
      rst_async = 1'b0;
      gate_a = 1'b0;
      gate_b = 1'b0;
      step("R3");
      chk("R3", cnt_q, 8'd0);
      for (int i = 0; i < 3; i++) step("R2");
      chk("R2", cnt_q, 8'd3);
   endtask

   task automatic t_both_high;
      logic [W-1:0] base;
      base = cnt_q;
      gate_a = 1'b1;
      gate_b = 1'b1;
      for (int i = 0; i < 4; i++) step("R2");
      chk("R2", cnt_q, base + 8'd4);
   endtask

   task automatic t_single;
      logic [W-1:0] base;
      base = cnt_q;
      gate_b = 1'b0;
      step("R3");
      chk("R3", cnt_q, base + 8'd1);
      for (int i = 0; i < 5; i++) step("R4");
      chk("R4", cnt_q, base + 8'd1);
   endtask

   task automatic t_resume_sync;
      logic [W-1:0] base;
      base = cnt_q;
      gate_b = 1'b1;
      step("R6");
      chk("R6", cnt_q, base);
      for (int i = 0; i < 3; i++) step("R6");
      chk("R6", cnt_q, base + 8'd3);
   endtask

   task automatic t_start_pulse;
      logic [W-1:0] base;
      gate_a = 1'b0;
      gate_b = 1'b1;
      step("R4");
      base = cnt_q;
      step("R4");
      step("R4");
      chk("R4", cnt_q, base);
      set_start(1'b1);
      for (int i = 0; i < 3; i++) step("R5");
      chk("R5", cnt_q, base + 8'd3);
      set_start(1'b0);
      step("R5");
      chk("R5", cnt_q, base + 8'd4);
      step("R6");
      step("R6");
      chk("R6", cnt_q, base + 8'd4);
   endtask

   task automatic t_async_reset;
      gate_a = 1'b0;
      gate_b = 1'b0;
      step("R2");
      step("R2");
      #2 rst_async = 1'b1;
      m_cnt = '0;
      m_run = 1'b0;
      #1 chk("R1", cnt_q, '0);
      set_start(1'b1);
      for (int i = 0; i < 3; i++) step("R9");
      chk("R9", cnt_q, '0);
      rst_async = 1'b0;
      step("R5");
      chk("R5", cnt_q, 8'd1);
      set_start(1'b0);
      step("R5");
   endtask

   task automatic t_wrap;
      rst_async = 1'b1;
      m_cnt = '0;
      m_run = 1'b0;
      gate_a = 1'b1;
      gate_b = 1'b1;
      step("R1");
      rst_async = 1'b0;
      for (int i = 0; i < 300 && m_cnt != 8'hFF; i++) step("R2");
      chk("R7", cnt_q, 8'hFF);
      step("R7");
      chk("R7", cnt_q, 8'h00);
      chk("R8", cnt_qb, 8'hFF);
      step("R7");
      chk("R7", cnt_q, 8'h01);
   endtask

   initial begin
      t_reset();
      t_both_high();
      t_single();
      t_resume_sync();
      t_start_pulse();
      t_async_reset();
      t_wrap();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule